// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block derives every digital timing strobe that an interline, progressive-scan CCD needs from one clock whose period is the timing unit. Each line is a fixed number of clock positions. Each frame is a whole number of lines.

Within a line the block drives these signals:
- a horizontal sync;
- two complementary horizontal shift clocks and a reset-gate strobe during the pixel transfer window;
- overlapping four-phase vertical shift controls during blanking;
- an electronic-shutter drain strobe during blanking.

Line 0 of every frame is the vertical blanking line. It carries the vertical sync and the sensor readout strobes.

Two scan modes exist. Full scan moves one row per line and fires both readout strobes. Fast scan fires only the first readout strobe and moves four rows per line, so only two of every eight rows reach the output. A fast-scan frame therefore has a quarter of the lines.

A small write port sets the scan mode and the shutter line. Written values are staged and take effect at the next frame start. An external level-shifting driver consumes the outputs, which are active-high logic levels.

Top module: `ccd_timing_gen`

In the requirements, "position" p is the clock count within a line (0 to LINE_LEN-1) and "line" v is the line count within a frame. All outputs are registered: the values visible in the cycle after clock edge n belong to the (p, v) that the generator held before that edge.

## Requirements
- R1: While rst is high every output is low. In the first cycle after rst falls, the outputs show line 0, position 0, with hd_o and vd_o high.
- R2: A line is LINE_LEN positions. hd_o is high for positions 0 to HSYNC_W-1 of every line and low elsewhere.
- R3: A frame is PROG_LINES lines in full scan and HFR_LINES lines in fast scan. vd_o is high for the whole of line 0 and low on all other lines.
- R4: Inside the transfer window (HACT_START <= p < HACT_END), h1_o is high on even positions and h2_o is its complement. Outside the window h1_o is high and h2_o is low.
- R5: rg_o is high exactly on the odd positions inside the transfer window, which gives one pulse per two-position pixel.
- R6: On line 0, for READ_OFS <= p < READ_OFS+READ_W, sg_a_o is high in both modes. sg_b_o is high in the same span only in full scan. Both are low everywhere else.
- R7: On lines 1 and later, a vertical window starts at VX_OFS. It holds 1 shift step in full scan and 4 in fast scan, and each step is four slots of SLOT_W positions. Slot s drives vert_o as 4'b0011, 4'b0110, 4'b1100 or 4'b1001 for s = 0 to 3. Outside the window vert_o is 0.
- R8: sub_o is high for SUB_OFS <= p < SUB_OFS+SUB_W on every line v below the active shutter line, and low otherwise.
- R9: A write changes nothing in the frame that is running. The staged mode and shutter line become active together at the next frame start, which is the edge leaving the last position of the last line.
- R10: A write happens when cfg_we is high at a clock edge. With cfg_sel = 0 it stages the mode from cfg_wdata[0] (0 = full scan, 1 = fast scan). With cfg_sel = 1 it stages the shutter line from all of cfg_wdata. Reset stages and activates full scan with shutter line 0.
- R11: Shutter line 0 gives no drain strobes. A shutter line at or beyond the frame length gives a strobe on every line, including line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing-unit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mode, 1 selects the shutter line |
| cfg_wdata | input | VW | Write data |
| hd_o | output | 1 | Horizontal sync |
| vd_o | output | 1 | Vertical sync |
| h1_o | output | 1 | Horizontal shift clock, first phase |
| h2_o | output | 1 | Horizontal shift clock, second phase |
| rg_o | output | 1 | Reset-gate strobe |
| sg_a_o | output | 1 | Readout strobe on the first phase-2 gate |
| sg_b_o | output | 1 | Readout strobe on the second phase-2 gate |
| vert_o | output | 4 | Four-phase vertical shift controls |
| sub_o | output | 1 | Electronic-shutter drain strobe |

## Verification
A table of mode and shutter-line pairs drives the generator, and every output is compared on every cycle of a whole frame against a model built from the requirements. The pairs cover both modes with a shutter line of zero, a mid-frame line, exactly the frame length and far beyond it. Together they separate the one-step from the four-step vertical window, the suppressed second readout strobe, and the shutter's line comparison at both ends. Directed runs write mid-frame to show that the running frame keeps its length and its drain strobes, and that a shutter write leaves the mode alone.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic {
    SCAN_FULL = 1'b0,
    SCAN_FAST = 1'b1
  } scan_mode_e;

  localparam int NPHASE     = 4;
  localparam int FAST_STEPS = 4;

  // true when pos lies in [start, start+len)
  function automatic logic in_span(int pos, int start, int len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // slot index inside the vertical shift window
  function automatic int vx_slot(int pos, int start, int slot_w);
    return ((pos - start) / slot_w) % NPHASE;
  endfunction

  // number of lines in one frame for a mode
  function automatic int frame_lines(scan_mode_e m, int full_lines, int fast_lines);
    return (m == SCAN_FAST) ? fast_lines : full_lines;
  endfunction

  // number of vertical shift steps per line for a mode
  function automatic int vx_steps(scan_mode_e m);
    return (m == SCAN_FAST) ? FAST_STEPS : 1;
  endfunction

endpackage

// File: rtl/ccd_tg_counters.sv
module ccd_tg_counters
  import ccd_tg_pkg::*;
#(
  parameter int LINE_LEN   = 800,
  parameter int PROG_LINES = 1068,
  parameter int HFR_LINES  = 267,
  parameter int HW         = 10,
  parameter int VW         = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  scan_mode_e    mode,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          frame_end_o
);

  logic line_end;
  logic last_line;

  assign line_end    = (int'(h_o) == LINE_LEN - 1);
  assign last_line   = (int'(v_o) == frame_lines(mode, PROG_LINES, HFR_LINES) - 1);
  assign frame_end_o = line_end && last_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_o <= '0;
      v_o <= '0;
    end else if (line_end) begin
      h_o <= '0;
      v_o <= last_line ? '0 : v_o + 1'b1;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (h_o == '0));

  // R3
  vline_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(v_o) < frame_lines(mode, PROG_LINES, HFR_LINES));

endmodule

// File: rtl/ccd_tg_cfg.sv
module ccd_tg_cfg
  import ccd_tg_pkg::*;
#(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [VW-1:0] cfg_wdata,
  input  logic          frame_end,
  output scan_mode_e    act_mode_o,
  output logic [VW-1:0] act_shut_o
);

  scan_mode_e    pend_mode;
  logic [VW-1:0] pend_shut;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode  <= SCAN_FULL;
      pend_shut  <= '0;
      act_mode_o <= SCAN_FULL;
      act_shut_o <= '0;
    end else begin
      if (cfg_we && !cfg_sel) pend_mode <= scan_mode_e'(cfg_wdata[0]);
      if (cfg_we &&  cfg_sel) pend_shut <= cfg_wdata;
      if (frame_end) begin
        act_mode_o <= pend_mode;
        act_shut_o <= pend_shut;
      end
    end
  end

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(act_mode_o));

  // R9
  shut_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(act_shut_o));

endmodule

// File: rtl/ccd_tg_decode.sv
module ccd_tg_decode
  import ccd_tg_pkg::*;
#(
  parameter int HW         = 10,
  parameter int VW         = 11,
  parameter int HSYNC_W    = 64,
  parameter int READ_OFS   = 2,
  parameter int READ_W     = 50,
  parameter int SUB_OFS    = 56,
  parameter int SUB_W      = 4,
  parameter int VX_OFS     = 60,
  parameter int SLOT_W     = 8,
  parameter int HACT_START = 200,
  parameter int HACT_END   = 790
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  scan_mode_e    mode,
  input  logic [VW-1:0] shut,
  output logic          hd_o,
  output logic          vd_o,
  output logic          h1_o,
  output logic          h2_o,
  output logic          rg_o,
  output logic          sg_a_o,
  output logic          sg_b_o,
  output logic [3:0]    vert_o,
  output logic          sub_o
);

  // named decode events
  logic       in_xfer;
  logic       in_read;
  logic       in_vx;
  logic       in_sub;
  logic       blank_line;
  logic [1:0] slot;
  logic [3:0] vert_d;

  assign blank_line = (v == '0);
  assign in_xfer    = in_span(int'(h), HACT_START, HACT_END - HACT_START);
  assign in_read    = blank_line && in_span(int'(h), READ_OFS, READ_W);
  assign in_vx      = !blank_line &&
                      in_span(int'(h), VX_OFS, vx_steps(mode) * NPHASE * SLOT_W);
  assign in_sub     = (v < shut) && in_span(int'(h), SUB_OFS, SUB_W);
  assign slot       = 2'(vx_slot(int'(h), VX_OFS, SLOT_W));

  for (genvar k = 0; k < NPHASE; k++) begin : g_phase
    assign vert_d[k] = in_vx && ((int'(slot) == k) ||
                                 (int'(slot) == (k + NPHASE - 1) % NPHASE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hd_o   <= 1'b0;
      vd_o   <= 1'b0;
      h1_o   <= 1'b0;
      h2_o   <= 1'b0;
      rg_o   <= 1'b0;
      sg_a_o <= 1'b0;
      sg_b_o <= 1'b0;
      vert_o <= '0;
      sub_o  <= 1'b0;
    end else begin
      hd_o   <= (int'(h) < HSYNC_W);
      vd_o   <= blank_line;
      h1_o   <= in_xfer ? !h[0] : 1'b1;
      h2_o   <= in_xfer ?  h[0] : 1'b0;
      rg_o   <= in_xfer &&  h[0];
      sg_a_o <= in_read;
      sg_b_o <= in_read && (mode == SCAN_FULL);
      vert_o <= vert_d;
      sub_o  <= in_sub;
    end
  end

  // R7
  vert_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(vert_o) == 0) || ($countones(vert_o) == 2));

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int LINE_LEN   = 800,
  parameter int PROG_LINES = 1068,
  parameter int HFR_LINES  = 267,
  parameter int HSYNC_W    = 64,
  parameter int READ_OFS   = 2,
  parameter int READ_W     = 50,
  parameter int SUB_OFS    = 56,
  parameter int SUB_W      = 4,
  parameter int VX_OFS     = 60,
  parameter int SLOT_W     = 8,
  parameter int HACT_START = 200,
  parameter int HACT_END   = 790,
  localparam int HW        = $clog2(LINE_LEN),
  localparam int VW        = $clog2(PROG_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [VW-1:0] cfg_wdata,
  output logic          hd_o,
  output logic          vd_o,
  output logic          h1_o,
  output logic          h2_o,
  output logic          rg_o,
  output logic          sg_a_o,
  output logic          sg_b_o,
  output logic [3:0]    vert_o,
  output logic          sub_o
);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          frame_end;
  scan_mode_e    act_mode;
  logic [VW-1:0] act_shut;
  logic          live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  ccd_tg_counters #(
    .LINE_LEN(LINE_LEN), .PROG_LINES(PROG_LINES), .HFR_LINES(HFR_LINES),
    .HW(HW), .VW(VW)
  ) u_cnt (
    .clk(clk), .rst(rst), .mode(act_mode),
    .h_o(h), .v_o(v), .frame_end_o(frame_end)
  );

  ccd_tg_cfg #(.VW(VW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_end(frame_end),
    .act_mode_o(act_mode), .act_shut_o(act_shut)
  );

  ccd_tg_decode #(
    .HW(HW), .VW(VW), .HSYNC_W(HSYNC_W), .READ_OFS(READ_OFS), .READ_W(READ_W),
    .SUB_OFS(SUB_OFS), .SUB_W(SUB_W), .VX_OFS(VX_OFS), .SLOT_W(SLOT_W),
    .HACT_START(HACT_START), .HACT_END(HACT_END)
  ) u_dec (
    .clk(clk), .rst(rst), .h(h), .v(v), .mode(act_mode), .shut(act_shut),
    .hd_o(hd_o), .vd_o(vd_o), .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o),
    .sg_a_o(sg_a_o), .sg_b_o(sg_b_o), .vert_o(vert_o), .sub_o(sub_o)
  );

  // R4
  hclk_compl_chk: assert property (@(posedge clk) disable iff (rst || !live)
    h1_o != h2_o);

  // R6
  sgb_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sg_b_o |-> (sg_a_o && act_mode == SCAN_FULL));

  // R3
  vd_hd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vd_o) |-> hd_o);

  // R5
  rg_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rg_o |-> h2_o);

endmodule

// File: tb/ccd_timing_gen_tb.sv
`timescale 1ns/1ps
module ccd_timing_gen_tb;

  localparam int LL  = 96;
  localparam int PL  = 16;
  localparam int FL  = 4;
  localparam int HS  = 4;
  localparam int RO  = 2;
  localparam int RWD = 6;
  localparam int SO  = 10;
  localparam int SWD = 4;
  localparam int VXO = 16;
  localparam int SL  = 2;
  localparam int HA  = 48;
  localparam int HE  = 92;
  localparam int VW  = $clog2(PL + 1);

  // table entry: {mode, shutter line}
  localparam int NCASE = 8;
  localparam logic [5:0] CASES [NCASE] = '{
    {1'b0, 5'd0}, {1'b0, 5'd5}, {1'b1, 5'd2}, {1'b1, 5'd0},
    {1'b0, 5'd16}, {1'b1, 5'd31}, {1'b0, 5'd1}, {1'b1, 5'd3}
  };
  localparam logic [3:0] PAT [4] = '{4'b0011, 4'b0110, 4'b1100, 4'b1001};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [VW-1:0] cfg_wdata = '0;
  logic hd, vd, h1, h2, rg, sga, sgb, sub;
  logic [3:0] vert;

  always #2.5 clk = ~clk;

  ccd_timing_gen #(
    .LINE_LEN(LL), .PROG_LINES(PL), .HFR_LINES(FL), .HSYNC_W(HS),
    .READ_OFS(RO), .READ_W(RWD), .SUB_OFS(SO), .SUB_W(SWD), .VX_OFS(VXO),
    .SLOT_W(SL), .HACT_START(HA), .HACT_END(HE)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hd_o(hd), .vd_o(vd), .h1_o(h1), .h2_o(h2),
    .rg_o(rg), .sg_a_o(sga), .sg_b_o(sgb), .vert_o(vert), .sub_o(sub)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs {hd,vd,h1,h2,rg,sga,sgb,vert[3:0],sub} from the requirements
  function automatic logic [11:0] model(int h, int v, bit fast, int shut);
    logic xf, rd, vx, e_sub;
    logic [3:0] vt;
    int win;
    xf    = (h >= HA) && (h < HE);
    rd    = (v == 0) && (h >= RO) && (h < RO + RWD);
    win   = (fast ? 4 : 1) * 4 * SL;
    vx    = (v != 0) && (h >= VXO) && (h < VXO + win);
    vt    = vx ? PAT[((h - VXO) / SL) % 4] : 4'b0000;
    e_sub = (v < shut) && (h >= SO) && (h < SO + SWD);
    return {h < HS, v == 0,
            xf ? (h % 2 == 0) : 1'b1, xf ? (h % 2 == 1) : 1'b0, xf && (h % 2 == 1),
            rd, rd && !fast, vt, e_sub};
  endfunction

  // bench position, staged and active settings
  int bh, bv, bshut, bshut_p;
  bit bfast, bfast_p, bvalid;
  logic [11:0] exp_v;

  always @(posedge clk) begin
    if (rst) begin
      bh <= 0; bv <= 0; bvalid <= 0; exp_v <= '0;
      bfast <= 0; bfast_p <= 0; bshut <= 0; bshut_p <= 0;
    end else begin
      bvalid <= 1;
      exp_v  <= model(bh, bv, bfast, bshut);
      if (cfg_we && !cfg_sel) bfast_p <= cfg_wdata[0];
      if (cfg_we &&  cfg_sel) bshut_p <= int'(cfg_wdata);
      if (bh == LL - 1) begin
        bh <= 0;
        if (bv == (bfast ? FL : PL) - 1) begin
          bv <= 0; bfast <= bfast_p; bshut <= bshut_p;
        end else bv <= bv + 1;
      end else bh <= bh + 1;
    end
  end

  // continuous comparison, counted per group:
  // 0 hd R2, 1 vd R3, 2 h1/h2 R4, 3 rg R5, 4 sg R6, 5 vert R7, 6 sub R8
  int err [7];
  int cyc = 0, rise_cnt = 0, rise_cyc = 0, last_len = 0;
  logic vd_q = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bvalid) begin
      if (hd != exp_v[11]) err[0]++;
      if (vd != exp_v[10]) err[1]++;
      if ({h1, h2} != exp_v[9:8]) err[2]++;
      if (rg != exp_v[7]) err[3]++;
      if ({sga, sgb} != exp_v[6:5]) err[4]++;
      if (vert != exp_v[4:1]) err[5]++;
      if (sub != exp_v[0]) err[6]++;
    end
    if (vd && !vd_q) begin
      last_len = cyc - rise_cyc;
      rise_cyc = cyc;
      rise_cnt = rise_cnt + 1;
    end
    vd_q = vd;
  end

  task automatic wr(bit sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = VW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_frame();
    int r;
    r = rise_cnt;
    wait (rise_cnt != r);
  endtask

  task automatic clear_err();
    @(posedge clk);
    foreach (err[i]) err[i] = 0;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    foreach (err[i]) err[i] = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outputs low in reset", int'({hd, vd, h1, h2, rg, sga, sgb, vert, sub}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle hd", int'(hd), 1);
    check("R1 first cycle vd", int'(vd), 1);

    // table of configurations, each checked over one whole frame
    for (int i = 0; i < NCASE; i++) begin
      wr(1'b0, int'(CASES[i][5]));   // R10 mode write
      wr(1'b1, int'(CASES[i][4:0])); // R10 shutter write, R11 at 0, 16 and 31
      wait_frame();
      clear_err();
      wait_frame();
      check("R2 hd", err[0], 0);
      check("R3 vd", err[1], 0);
      check("R4 h1/h2", err[2], 0);
      check("R5 rg", err[3], 0);
      check("R6 readout", err[4], 0);
      check("R7 vertical", err[5], 0);
      check("R8 shutter", err[6], 0);
      check("R3 frame length", last_len, (CASES[i][5] ? FL : PL) * LL);
    end

    // R9: mode written mid-frame leaves the running frame's length
    wr(1'b0, 0); wr(1'b1, 0);
    wait_frame(); wait_frame();
    repeat (3 * LL) @(negedge clk);
    wr(1'b0, 1);
    wait_frame();
    check("R9 running frame keeps full length", last_len, PL * LL);
    wait_frame();
    check("R3 fast frame length", last_len, FL * LL);

    // R9: shutter written at frame start gives no strobe in that frame
    wr(1'b1, 16);
    n = 0;
    begin
      int r;
      r = rise_cnt;
      while (rise_cnt == r) begin @(negedge clk); if (sub) n++; end
    end
    check("R9 shutter held until frame end", n, 0);
    n = 0;
    begin
      int r;
      r = rise_cnt;
      while (rise_cnt == r) begin @(negedge clk); if (sub) n++; end
    end
    check("R11 shutter beyond frame strobes every line", n, FL * SWD);
    check("R10 shutter write keeps mode", last_len, FL * LL);
    check("R8 no mismatch in directed runs", err[6], 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule